// File: doc/BRIEF.md
# Run-Time Signed/Unsigned Registered Multiplier

This block multiplies two operands whose number format is picked cycle by cycle. Each operand has its own control bit. When the bit is high, the operand is read as two's complement. When it is low, the operand is read as an unsigned magnitude. The block returns the product at full precision, together with a flag that tells downstream logic whether to read that product as signed.

The operand width is a parameter. Internally the block rounds that width up to one of three native sizes: 9, 12 or 18 bits. A narrower operand is placed in the upper bits of the native word and the freed low bits are filled with zeros. The product is therefore the true product scaled by a power of two, and it is twice the native width. For example, a 16-bit operand becomes an 18-bit word and the product is 36 bits wide.

Operands and controls pass through an input register and then an output register. Both registers advance on the rising clock edge when the enable is high. Both are cleared at once by an asynchronous clear.

Top module: `dynsign_mult`

## Requirements
- R1: The native size is 9 for operand widths 1 to 9, 12 for widths 10 to 12 and 18 for widths 13 to 18, and the product port is twice the native size (36 bits at the default width of 16, 24 bits at width 12).
- R2: A narrower operand is shifted up by (native − width) bits with zeros below it, so the product equals the true product times 2^(2·(native − width)), and its lowest 2·(native − width) bits are always zero.
- R3: With `a_is_signed` = 1, operand A is read as two's complement; with it at 0, A is read as unsigned.
- R4: With `b_is_signed` = 1, operand B is read as two's complement; with it at 0, B is read as unsigned.
- R5: `prod_signed` is 1 when at least one operand was marked signed, and 0 only when both were unsigned; it travels with its product.
- R6: With both sign controls low, the product is the unsigned product of the two operands.
- R7: The product is exact for every sign pairing, including the extremes: most-negative × most-negative, all-ones unsigned × all-ones unsigned, and most-negative signed × all-ones unsigned.
- R8: With the enable held high, an operand pair presented before rising edge k appears on `prod` just after rising edge k+1.
- R9: While the enable is low, neither register changes: `prod` and `prod_signed` hold, whatever the inputs do.
- R10: Raising `clr` sets `prod` and `prod_signed` to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| en | input | 1 | Clock enable for both register stages |
| a_in | input | OP_W | Operand A |
| b_in | input | OP_W | Operand B |
| a_is_signed | input | 1 | 1: A is two's complement, 0: A is unsigned |
| b_is_signed | input | 1 | 1: B is two's complement, 0: B is unsigned |
| prod | output | 2·native | Full-precision product |
| prod_signed | output | 1 | 1 when the product is to be read as signed |

## Verification
The bench tests the extreme operand pairs under each sign pairing. A design that sign-extends an operand marked unsigned would return a negative result for all-ones × all-ones. A design that zero-extends an operand marked signed would lose the sign of the most-negative value. It checks that the low bits of the product are zero and that the product carries the padding scale. Putting the padding in the MSBs, or dropping it, would shift every product by the wrong amount. Separate instances cover the padded and the unpadded variants. It also tests the flag under all four pairings, holds the enable low while the inputs change, and raises the clear between clock edges. A flag taken from one operand only, a stage that ignores the enable, or a clear that waits for a clock edge would each produce a visible mismatch.

// File: rtl/dsm_pkg.sv
// Shared constants and helpers for the run-time signed multiplier.
package dsm_pkg;

   // Widest operand the block accepts.
   localparam int MAX_OPERAND_W = 18;

   // Round an operand width up to the nearest native multiplier size.
   function automatic int native_width(input int w);
      if (w <= 9)
         return 9;
      else if (w <= 12)
         return 12;
      return 18;
   endfunction

endpackage

// File: rtl/dsm_operand_stage.sv
// Input register for one operand: LSB zero-padding to the native size,
// then a register with enable and asynchronous clear.
module dsm_operand_stage #(
   parameter int OP_W  = 16,
   parameter int NAT_W = 18
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic [OP_W-1:0]  din,
   input  logic             sgn_in,
   output logic [NAT_W-1:0] dout,
   output logic             sgn_out
);

   localparam int PAD_W = NAT_W - OP_W;

   logic [NAT_W-1:0] padded;

   // The padding variant is picked by the width gap.
   generate
      if (PAD_W < 0) begin : g_bad_pad
         $error("dsm_operand_stage: operand wider than native size");
      end else if (PAD_W == 0) begin : g_no_pad
         assign padded = din;
      end else begin : g_lsb_pad
         assign padded = {din, {PAD_W{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         dout    <= '0;
         sgn_out <= 1'b0;
      end else if (en) begin
         dout    <= padded;
         sgn_out <= sgn_in;
      end
   end

endmodule

// File: rtl/dsm_signed_core.sv
// Combinational multiply. Each operand gets one extra top bit, driven by
// (its sign control AND its MSB), so that a single signed multiply covers
// all four sign pairings exactly.
module dsm_signed_core #(
   parameter int NAT_W = 18
) (
   input  logic [NAT_W-1:0]   a,
   input  logic [NAT_W-1:0]   b,
   input  logic               sa,
   input  logic               sb,
   output logic [2*NAT_W-1:0] p
);

   localparam int EXT_W  = NAT_W + 1;
   localparam int FULL_W = 2 * EXT_W;
   localparam int OUT_W  = 2 * NAT_W;

   logic signed [EXT_W-1:0]  a_ext;
   logic signed [EXT_W-1:0]  b_ext;
   logic signed [FULL_W-1:0] full;
   logic                     unused_top;

   assign a_ext = $signed({sa & a[NAT_W-1], a});
   assign b_ext = $signed({sb & b[NAT_W-1], b});
   assign full  = a_ext * b_ext;

   // Every sign pairing fits in OUT_W bits. The top two bits only repeat the sign.
   assign p          = full[OUT_W-1:0];
   assign unused_top = ^full[FULL_W-1:OUT_W];

endmodule

// File: rtl/dsm_result_stage.sv
// Output register for the product and its signedness flag.
module dsm_result_stage #(
   parameter int W = 36
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] d,
   input  logic         flag_d,
   output logic [W-1:0] q,
   output logic         flag_q
);

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         q      <= '0;
         flag_q <= 1'b0;
      end else if (en) begin
         q      <= d;
         flag_q <= flag_d;
      end
   end

endmodule

// File: rtl/dynsign_mult.sv
// Registered multiplier with per-operand run-time sign selection.
module dynsign_mult #(
   parameter  int OP_W   = 16,
   localparam int NAT_W  = dsm_pkg::native_width(OP_W),
   localparam int PROD_W = 2 * NAT_W
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              en,
   input  logic [OP_W-1:0]   a_in,
   input  logic [OP_W-1:0]   b_in,
   input  logic              a_is_signed,
   input  logic              b_is_signed,
   output logic [PROD_W-1:0] prod,
   output logic              prod_signed
);

   localparam int PAD = NAT_W - OP_W;

   generate
      if (OP_W < 1 || OP_W > dsm_pkg::MAX_OPERAND_W) begin : g_bad_width
         $error("dynsign_mult: OP_W out of range 1..18");
      end
   endgenerate

   logic [NAT_W-1:0]  a_q;
   logic [NAT_W-1:0]  b_q;
   logic              sa_q;
   logic              sb_q;
   logic [PROD_W-1:0] p_comb;
   logic              flag_comb;

   dsm_operand_stage #(.OP_W(OP_W), .NAT_W(NAT_W)) u_stage_a (
      .clk(clk), .clr(clr), .en(en),
      .din(a_in), .sgn_in(a_is_signed),
      .dout(a_q), .sgn_out(sa_q)
   );

   dsm_operand_stage #(.OP_W(OP_W), .NAT_W(NAT_W)) u_stage_b (
      .clk(clk), .clr(clr), .en(en),
      .din(b_in), .sgn_in(b_is_signed),
      .dout(b_q), .sgn_out(sb_q)
   );

   dsm_signed_core #(.NAT_W(NAT_W)) u_core (
      .a(a_q), .b(b_q), .sa(sa_q), .sb(sb_q), .p(p_comb)
   );

   // The result is signed if either operand is signed.
   assign flag_comb = sa_q | sb_q;

   dsm_result_stage #(.W(PROD_W)) u_out (
      .clk(clk), .clr(clr), .en(en),
      .d(p_comb), .flag_d(flag_comb),
      .q(prod), .flag_q(prod_signed)
   );

endmodule

// File: rtl/dsm_checker.sv
// Property checker bound to every dynsign_mult instance.
module dsm_checker #(
   parameter int PROD_W   = 36,
   parameter int PAD_BITS = 2
) (
   input logic              clk,
   input logic              clr,
   input logic              en,
   input logic              a_is_signed,
   input logic              b_is_signed,
   input logic [PROD_W-1:0] prod,
   input logic              prod_signed
);

   // Edges seen since the last clear, saturating at 3.
   logic [1:0] since_clr;
   always_ff @(posedge clk or posedge clr) begin
      if (clr)
         since_clr <= 2'd0;
      else if (since_clr != 2'd3)
         since_clr <= since_clr + 2'd1;
   end

   // R5: the flag two enabled edges later is the OR of the sign controls.
   p_flag_follows_r5: assert property (@(posedge clk) disable iff (clr)
      (since_clr >= 2'd2 && $past(en) && $past(en, 2)) |->
      (prod_signed == ($past(a_is_signed, 2) | $past(b_is_signed, 2))));

   // R9: with the enable low, the output holds.
   p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (clr)
      (since_clr >= 2'd1 && !$past(en)) |-> ($stable(prod) && $stable(prod_signed)));

   // R10: while clear was high the outputs sat at zero.
   p_cleared_r10: assert property (@(posedge clk) disable iff (clr)
      $fell(clr) |-> (prod == '0 && !prod_signed));

   // R2: the padding bits of the product stay zero.
   generate
      if (PAD_BITS > 0) begin : g_pad_chk
         p_low_zero_r2: assert property (@(posedge clk) disable iff (clr)
            prod[2*PAD_BITS-1:0] == '0);
      end
   endgenerate

endmodule

bind dynsign_mult dsm_checker #(.PROD_W(PROD_W), .PAD_BITS(PAD)) u_chk (
   .clk(clk), .clr(clr), .en(en),
   .a_is_signed(a_is_signed), .b_is_signed(b_is_signed),
   .prod(prod), .prod_signed(prod_signed)
);

// File: tb/dynsign_mult_tb_top.sv
module dynsign_mult_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        clr = 1'b1;
   logic        en  = 1'b1;
   logic [15:0] a16 = '0, b16 = '0;
   logic        sa16 = 1'b0, sb16 = 1'b0;
   logic [35:0] p16;
   logic        f16;
   logic [11:0] a12 = '0, b12 = '0;
   logic        sa12 = 1'b0, sb12 = 1'b0;
   logic [23:0] p12;
   logic        f12;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dynsign_mult #(.OP_W(16)) dut_i (
      .clk(clk), .clr(clr), .en(en), .a_in(a16), .b_in(b16),
      .a_is_signed(sa16), .b_is_signed(sb16), .prod(p16), .prod_signed(f16)
   );

   dynsign_mult #(.OP_W(12)) dut_n_i (
      .clk(clk), .clr(clr), .en(en), .a_in(a12), .b_in(b12),
      .a_is_signed(sa12), .b_is_signed(sb12), .prod(p12), .prod_signed(f12)
   );

   typedef struct {
      logic [35:0] p;
      logic        f;
      int          due;
      string       req;
   } item_t;
   item_t sbq[$];

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Reference for the 16-bit instance: 2 pad bits per operand, so a scale of 16.
   function automatic logic [35:0] ref16(logic [15:0] a, logic [15:0] b,
                                         logic sa, logic sb);
      longint av, bv, pv;
      av = sa ? longint'($signed(a)) : longint'({48'd0, a});
      bv = sb ? longint'($signed(b)) : longint'({48'd0, b});
      pv = av * bv * 16;
      return pv[35:0];
   endfunction

   function automatic logic [23:0] ref12(logic [11:0] a, logic [11:0] b,
                                         logic sa, logic sb);
      longint av, bv, pv;
      av = sa ? longint'($signed(a)) : longint'({52'd0, a});
      bv = sb ? longint'($signed(b)) : longint'({52'd0, b});
      pv = av * bv;
      return pv[23:0];
   endfunction

   // Driver: apply one pair and queue its expected result (R8 timing).
   task automatic send(logic [15:0] a, logic [15:0] b, logic sa, logic sb, string req);
      item_t it;
      @(negedge clk);
      a16 = a; b16 = b; sa16 = sa; sb16 = sb;
      it.p = ref16(a, b, sa, sb);
      it.f = sa | sb;
      it.due = cyc + 2;
      it.req = req;
      sbq.push_back(it);
   endtask

   // Monitor: compare results as they come out.
   always @(posedge clk) begin
      #1;
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
         item_t it;
         it = sbq.pop_front();
         check(it.req, {28'd0, p16}, {28'd0, it.p});
         check("R5 flag", {63'd0, f16}, {63'd0, it.f});
         check("R2 low bits", {60'd0, p16[3:0]}, 64'd0);
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      string tag;
      // Reset state, R10
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset prod", {28'd0, p16}, 64'd0);
      check("R10 reset flag", {63'd0, f16}, 64'd0);
      // R1: product widths
      check("R1 width 16", $bits(p16), 36);
      check("R1 width 12", $bits(dut_n_i.prod), 24);
      @(negedge clk);
      clr = 1'b0;

      // R8 latency, R6 unsigned, with the R1/R2 unpadded variant alongside
      @(negedge clk);
      a16 = 16'd3; b16 = 16'd5;
      a12 = 12'h800; b12 = 12'h7FF; sa12 = 1'b1; sb12 = 1'b0;
      @(posedge clk); #1;
      check("R8 not yet", {28'd0, p16}, 64'd0);
      @(posedge clk); #1;
      check("R8 R6 latency", {28'd0, p16}, 64'd240);
      check("R1 R3 width12", {40'd0, p12}, {40'd0, ref12(12'h800, 12'h7FF, 1'b1, 1'b0)});
      check("R5 flag12", {63'd0, f12}, 64'd1);
      @(negedge clk);
      a12 = 12'h800; b12 = 12'h800; sa12 = 1'b1; sb12 = 1'b1;
      repeat (2) @(posedge clk); #1;
      check("R7 width12 min*min", {40'd0, p12}, 64'd4194304);

      // R9 hold
      @(negedge clk);
      en = 1'b0; a16 = 16'd7; b16 = 16'd9; sa16 = 1'b1; sb16 = 1'b1;
      repeat (3) @(posedge clk); #1;
      check("R9 hold prod", {28'd0, p16}, 64'd240);
      check("R9 hold flag", {63'd0, f16}, 64'd0);
      @(negedge clk);
      en = 1'b1;
      repeat (2) @(posedge clk); #1;
      check("R9 resume", {28'd0, p16}, 64'd1008);

      // R7 corners
      send(16'h8000, 16'h8000, 1'b1, 1'b1, "R7 min*min");
      send(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, "R7 umax*umax");
      send(16'h8000, 16'hFFFF, 1'b1, 1'b0, "R7 min*umax");
      send(16'hFFFF, 16'h8000, 1'b0, 1'b1, "R7 umax*min");
      send(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R7 -1*umax");
      send(16'h7FFF, 16'h8000, 1'b1, 1'b1, "R7 max*min");

      // Random operands under all four sign pairings
      for (int c = 0; c < 4; c++) begin
         for (int i = 0; i < 40; i++) begin
            case (c)
               0: tag = "R6 uu";
               1: tag = "R3 su";
               2: tag = "R4 us";
               default: tag = "R3 R4 ss";
            endcase
            send(16'($urandom), 16'($urandom), c[0], c[1], tag);
         end
      end
      repeat (4) @(posedge clk);
      #1;
      check("R8 drained", sbq.size(), 0);

      // R10 asynchronous clear between edges
      @(posedge clk);
      #2;
      clr = 1'b1;
      #1;
      check("R10 async prod", {28'd0, p16}, 64'd0);
      check("R10 async flag", {63'd0, f16}, 64'd0);
      check("R10 async prod12", {40'd0, p12}, 64'd0);
      @(negedge clk);
      clr = 1'b0;
      repeat (2) @(posedge clk);

      summary();
      $finish;
   end

endmodule